// File: doc/BRIEF.md
# Single-Level Page Table Walker

The walker turns a virtual address into a physical address with one read of an in-memory page table. A requester presents a virtual address and an access kind (load, store or instruction fetch). The walker splits the address into a virtual page number and a page offset. It computes the address of the table entry as the table base register plus four times the page number, and it issues exactly one word read on its memory port. When the entry word comes back, the walker decodes it. It then returns one of three results: the physical address (physical page number joined with the unchanged offset), a page fault for an entry marked not present, or a protection fault when the entry's rights do not allow the requested access.

The table base register is written through a dedicated port. Loading a new base moves all later translations to another table, which is how one address space is swapped for another. Only one translation is in flight at a time. A base write that arrives while a walk is busy is held back and applied once that walk's response has been accepted, so the walk in flight always finishes against the table it started with.

Top module: `page_walker`

## Requirements
- R1: A permitted translation returns rspPaddr equal to the entry's physical page number (entry bits 21:0 by default) shifted left by the offset width, ORed with the virtual offset (vaddr bits 9:0 by default, 1 KB pages), with rspFault low.
- R2: Each accepted request causes exactly one memory read. Its address is base + 4 * vpn, where vpn = vaddr >> OFFSET_W, taken modulo 2^PADDR_W. memReqValid stays high with a stable address until memReqReady, and drops in the cycle after the handshake.
- R3: An entry word is decoded as: bit 31 present, bits 30:29 rights (0 read-only, 1 read/write, 2 execute-only, 3 no access), and the low PPN_W bits the physical page number.
- R4: An entry whose present bit is 0 produces rspFault=1 with rspCause=0, whatever its rights and the access kind.
- R5: For a present entry, reqAccess (0 load, 1 store, 2 fetch, 3 reserved) is allowed only in these pairs: a load with rights 0 or 1, a store with rights 1, and a fetch with rights 2. Any other pairing gives rspFault=1 with rspCause=1.
- R6: Every response returns the requesting virtual address on rspVaddr. A faulting response drives rspPaddr to zero.
- R7: reqReady is high only when the walker is idle. It falls in the cycle after a request is accepted and rises again only after the response handshake. rspValid stays high, with stable fields, until rspReady.
- R8: A base write while idle takes effect for the next accepted request. A base write in the same cycle as a request acceptance does not change that request's entry address, but it does apply to the following request.
- R9: Base writes during a walk are deferred until its response handshake, and only the last such write is kept. The walk in flight uses the old base, and the next walk uses the last value written.
- R10: After reset, reqReady=1, memReqValid=0, rspValid=0 and the base register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and accepting |
| reqVaddr | input | VADDR_W | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response consumed |
| rspFault | output | 1 | Translation failed |
| rspCause | output | 1 | Fault cause: 0 not present, 1 protection |
| rspPaddr | output | PADDR_W | Physical address, zero on fault |
| rspVaddr | output | VADDR_W | Virtual address of the request |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | PADDR_W | Byte address of the entry |
| memRspValid | input | 1 | Entry data returned |
| memRspData | input | 32 | Entry word |
| baseWrEn | input | 1 | Write the table base register |
| baseWrData | input | PADDR_W | New table base |

## Verification
Two functions can fall on the same clock edge: a base register write and either the acceptance of a request or a walk already in progress. The bench drives a base write in the exact cycle a request is accepted, and it issues two back-to-back writes while the entry read is still stalled. It checks the entry address of the current walk against the old base and the address of the following walk against the newest written value. A full sweep over present bit, rights code and access kind, with varied memory stalls and response back-pressure, judges the fault decision and the physical address, computing each result arithmetically.

// File: rtl/pw_pkg.sv
package pw_pkg;

  localparam int ENTRY_W    = 32;
  localparam int PRESENT_B  = 31;
  localparam int RIGHTS_HI  = 30;
  localparam int RIGHTS_LO  = 29;

  localparam logic [1:0] RIGHT_RO   = 2'd0;
  localparam logic [1:0] RIGHT_RW   = 2'd1;
  localparam logic [1:0] RIGHT_EXEC = 2'd2;

  localparam logic [1:0] ACC_LOAD   = 2'd0;
  localparam logic [1:0] ACC_STORE  = 2'd1;
  localparam logic [1:0] ACC_FETCH  = 2'd2;

  localparam logic CAUSE_ABSENT  = 1'b0;
  localparam logic CAUSE_PROTECT = 1'b1;

  typedef struct packed {
    logic captureReq;
    logic captureEntry;
    logic walkBusy;
    logic walkDone;
  } walkStrobes_t;

  function automatic logic accessAllowed(input logic [1:0] rights, input logic [1:0] acc);
    logic ok;
    ok = 1'b0;
    case (acc)
      ACC_LOAD:  ok = (rights == RIGHT_RO) || (rights == RIGHT_RW);
      ACC_STORE: ok = (rights == RIGHT_RW);
      ACC_FETCH: ok = (rights == RIGHT_EXEC);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  output logic         memReqValid,
  input  logic         memReqReady,
  input  logic         memRspValid,
  output logic         rspValid,
  input  logic         rspReady,
  output walkStrobes_t strobes
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_REPLY = 2'd3
  } walkState_t;

  walkState_t stateQ, stateD;

  always_comb begin
    stateD               = stateQ;
    reqReady             = 1'b0;
    memReqValid          = 1'b0;
    rspValid             = 1'b0;
    strobes.captureReq   = 1'b0;
    strobes.captureEntry = 1'b0;
    strobes.walkDone     = 1'b0;
    strobes.walkBusy     = (stateQ != ST_IDLE);
    case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobes.captureReq = 1'b1;
          stateD             = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobes.captureEntry = 1'b1;
          stateD               = ST_REPLY;
        end
      end
      ST_REPLY: begin
        rspValid = 1'b1;
        if (rspReady) begin
          strobes.walkDone = 1'b1;
          stateD           = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R7
  accept_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // R2
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  // R2
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqReady, memReqValid, rspValid}));

endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int VADDR_W  = 32,
  parameter int PADDR_W  = 32,
  parameter int OFFSET_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobes_t       strobes,
  input  logic [VADDR_W-1:0] reqVaddr,
  input  logic [1:0]         reqAccess,
  input  logic               baseWrEn,
  input  logic [PADDR_W-1:0] baseWrData,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic [PADDR_W-1:0] memReqAddr,
  output logic               rspFault,
  output logic               rspCause,
  output logic [PADDR_W-1:0] rspPaddr,
  output logic [VADDR_W-1:0] rspVaddr
);

  localparam int VPN_W = VADDR_W - OFFSET_W;
  localparam int PPN_W = PADDR_W - OFFSET_W;

  logic [PADDR_W-1:0] baseQ;
  logic [PADDR_W-1:0] pendQ;
  logic               pendValidQ;
  logic [VADDR_W-1:0] vaddrQ;
  logic [1:0]         accQ;
  logic [PADDR_W-1:0] entryAddrQ;
  logic [ENTRY_W-1:0] entryQ;

  logic [VPN_W-1:0]    reqVpn;
  logic [PADDR_W-1:0]  entryAddrD;
  logic                entPresent;
  logic [1:0]          entRights;
  logic [PPN_W-1:0]    entPpn;
  logic                permitted;
  logic [OFFSET_W-1:0] pageOffset;
  logic                unusedEntryBits;

  // Entry address: table base plus one word per virtual page
  assign reqVpn     = reqVaddr[VADDR_W-1:OFFSET_W];
  assign entryAddrD = baseQ + (PADDR_W'(reqVpn) << 2);

  // Base register with deferral of writes that land during a walk
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ      <= '0;
      pendQ      <= '0;
      pendValidQ <= 1'b0;
    end else if (!strobes.walkBusy) begin
      if (baseWrEn) baseQ <= baseWrData;
      pendValidQ <= 1'b0;
    end else if (strobes.walkDone) begin
      if (baseWrEn)        baseQ <= baseWrData;
      else if (pendValidQ) baseQ <= pendQ;
      pendValidQ <= 1'b0;
    end else if (baseWrEn) begin
      pendQ      <= baseWrData;
      pendValidQ <= 1'b1;
    end
  end

  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ     <= '0;
      accQ       <= '0;
      entryAddrQ <= '0;
    end else if (strobes.captureReq) begin
      vaddrQ     <= reqVaddr;
      accQ       <= reqAccess;
      entryAddrQ <= entryAddrD;
    end
  end

  // Entry capture
  always_ff @(posedge clk) begin
    if (!rstN)                     entryQ <= '0;
    else if (strobes.captureEntry) entryQ <= memRspData;
  end

  // Entry decode
  assign entPresent      = entryQ[PRESENT_B];
  assign entRights       = entryQ[RIGHTS_HI:RIGHTS_LO];
  assign entPpn          = entryQ[PPN_W-1:0];
  assign unusedEntryBits = ^entryQ[RIGHTS_LO-1:PPN_W];
  assign permitted       = accessAllowed(entRights, accQ);
  assign pageOffset      = vaddrQ[OFFSET_W-1:0];

  always_comb begin
    rspFault = 1'b0;
    rspCause = CAUSE_ABSENT;
    rspPaddr = '0;
    if (!entPresent) begin
      rspFault = 1'b1;
      rspCause = CAUSE_ABSENT;
    end else if (!permitted) begin
      rspFault = 1'b1;
      rspCause = CAUSE_PROTECT;
    end else begin
      rspPaddr = {entPpn, pageOffset};
    end
  end

  assign rspVaddr   = vaddrQ;
  assign memReqAddr = entryAddrQ;

  // R9
  pend_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.walkDone |=> !pendValidQ);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.walkBusy && !strobes.captureReq) |=> $stable(entryAddrQ) || !strobes.walkBusy);

  // R8
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.walkBusy && !strobes.walkDone) |=> $stable(baseQ));

endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int VADDR_W  = 32,
  parameter int PADDR_W  = 32,
  parameter int OFFSET_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VADDR_W-1:0] reqVaddr,
  input  logic [1:0]         reqAccess,
  output logic               rspValid,
  input  logic               rspReady,
  output logic               rspFault,
  output logic               rspCause,
  output logic [PADDR_W-1:0] rspPaddr,
  output logic [VADDR_W-1:0] rspVaddr,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [PADDR_W-1:0] memReqAddr,
  input  logic               memRspValid,
  input  logic [31:0]        memRspData,
  input  logic               baseWrEn,
  input  logic [PADDR_W-1:0] baseWrData
);

  walkStrobes_t strobes;

  pw_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspValid    (rspValid),
    .rspReady    (rspReady),
    .strobes     (strobes)
  );

  pw_datapath #(
    .VADDR_W  (VADDR_W),
    .PADDR_W  (PADDR_W),
    .OFFSET_W (OFFSET_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqVaddr   (reqVaddr),
    .reqAccess  (reqAccess),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .rspFault   (rspFault),
    .rspCause   (rspCause),
    .rspPaddr   (rspPaddr),
    .rspVaddr   (rspVaddr)
  );

  // R6
  fault_no_paddr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspPaddr == '0));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspPaddr[OFFSET_W-1:0] == rspVaddr[OFFSET_W-1:0]));

  // R7
  rsp_fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> ($stable(rspPaddr) && $stable(rspFault) && $stable(rspCause)));

endmodule

// File: tb/tb_page_walker.sv
module tb_page_walker;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 32;
  localparam int PW = 32;
  localparam int OW = 10;
  localparam int WATCHDOG = 50000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [VW-1:0] reqVaddr = '0;
  logic [1:0]    reqAccess = '0;
  logic          rspValid;
  logic          rspReady = 1'b0;
  logic          rspFault;
  logic          rspCause;
  logic [PW-1:0] rspPaddr;
  logic [VW-1:0] rspVaddr;
  logic          memReqValid;
  logic          memReqReady = 1'b0;
  logic [PW-1:0] memReqAddr;
  logic          memRspValid = 1'b0;
  logic [31:0]   memRspData = '0;
  logic          baseWrEn = 1'b0;
  logic [PW-1:0] baseWrData = '0;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_walker #(.VADDR_W(VW), .PADDR_W(PW), .OFFSET_W(OW)) dut (.*);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkEntry(input bit present, input logic [1:0] rights, input logic [21:0] ppn);
    return {present, rights, 7'd0, ppn};
  endfunction

  // One full walk; expBase is the base that this walk must use
  task automatic doWalk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] entry,
                        input logic [31:0] expBase, input int stall,
                        input bit wrAtAccept, input logic [31:0] wrAcceptVal,
                        input bit wrDuring, input logic [31:0] wrDuringVal);
    logic [31:0] expAddr, expPaddr;
    logic expFault, expCause, ok;
    expAddr = expBase + ({10'd0, va[31:10]} << 2);
    case (acc)
      2'd0: ok = (entry[30:29] == 2'd0) || (entry[30:29] == 2'd1);
      2'd1: ok = (entry[30:29] == 2'd1);
      2'd2: ok = (entry[30:29] == 2'd2);
      default: ok = 1'b0;
    endcase
    if (!entry[31])  begin expFault = 1'b1; expCause = 1'b0; expPaddr = '0; end
    else if (!ok)    begin expFault = 1'b1; expCause = 1'b1; expPaddr = '0; end
    else             begin expFault = 1'b0; expCause = 1'b0; expPaddr = {entry[21:0], va[9:0]}; end

    @(negedge clk);
    check("R7", "reqReady idle", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqVaddr = va; reqAccess = acc;
    baseWrEn = wrAtAccept; baseWrData = wrAcceptVal;
    @(negedge clk);
    reqValid = 1'b0; baseWrEn = 1'b0;
    check("R7", "reqReady after accept", {31'd0, reqReady}, 32'd0);
    if (wrDuring) begin
      baseWrEn = 1'b1; baseWrData = wrDuringVal ^ 32'h0000_4000;
      @(negedge clk);
      baseWrData = wrDuringVal;
      @(negedge clk);
      baseWrEn = 1'b0;
    end
    for (int s = 0; s < stall % 3; s++) @(negedge clk);
    check("R2", "memReqValid held", {31'd0, memReqValid}, 32'd1);
    check("R2", "entry address", memReqAddr, expAddr);
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    check("R2", "single read", {31'd0, memReqValid}, 32'd0);
    for (int s = 0; s < stall % 4; s++) @(negedge clk);
    memRspValid = 1'b1; memRspData = entry;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = 32'hDEAD_BEEF;
    for (int s = 0; s < stall % 2; s++) begin
      check("R7", "rspValid held", {31'd0, rspValid}, 32'd1);
      @(negedge clk);
    end
    check("R7", "rspValid", {31'd0, rspValid}, 32'd1);
    check("R4/R5", "rspFault", {31'd0, rspFault}, {31'd0, expFault});
    if (expFault) check(entry[31] ? "R5" : "R4", "rspCause", {31'd0, rspCause}, {31'd0, expCause});
    check(expFault ? "R6" : "R1", "rspPaddr", rspPaddr, expPaddr);
    check("R6", "rspVaddr", rspVaddr, va);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    check("R7", "reqReady after response", {31'd0, reqReady}, 32'd1);
  endtask

  task automatic writeBase(input logic [31:0] v);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = v;
    @(negedge clk);
    baseWrEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reqReady", {31'd0, reqReady}, 32'd1);
    check("R10", "memReqValid", {31'd0, memReqValid}, 32'd0);
    check("R10", "rspValid", {31'd0, rspValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "reqReady out of reset", {31'd0, reqReady}, 32'd1);
    // R10 base is zero: first walk must read at 4*vpn
    doWalk(32'h0000_0C05, 2'd0, mkEntry(1, 2'd0, 22'h12), 32'h0, 1, 0, 0, 0, 0);

    // R8 idle write, then R3/R4/R5 sweep over present x rights x access
    writeBase(32'h0001_0000);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++)
        for (int a = 0; a < 4; a++) begin
          int i;
          logic [31:0] va;
          logic [21:0] ppn;
          i   = p * 16 + r * 4 + a;
          va  = {22'(i * 37 + 5), 10'(i * 13 + 1)};
          ppn = 22'(i * 1111 + 3);
          doWalk(va, 2'(a), mkEntry(p[0], 2'(r), ppn), 32'h0001_0000, i, 0, 0, 0, 0);
        end

    // R8 base write in the acceptance cycle: this walk old base, next walk new
    doWalk(32'h0040_0123, 2'd1, mkEntry(1, 2'd1, 22'h2AA), 32'h0001_0000, 2, 1, 32'h0000_8000, 0, 0);
    doWalk(32'h0040_0123, 2'd2, mkEntry(1, 2'd2, 22'h155), 32'h0000_8000, 3, 0, 0, 0, 0);

    // R9 two writes during a walk: deferred, last one wins
    doWalk(32'h1234_5678, 2'd0, mkEntry(1, 2'd1, 22'h3FF), 32'h0000_8000, 1, 0, 0, 1, 32'h0002_0000);
    doWalk(32'h1234_5678, 2'd0, mkEntry(1, 2'd1, 22'h3FF), 32'h0002_0000, 0, 0, 0, 0, 0);

    // R1/R2 boundary: all-ones address and page number, address wraps
    writeBase(32'hFFFF_F000);
    doWalk(32'hFFFF_FFFF, 2'd0, mkEntry(1, 2'd0, 22'h3F_FFFF), 32'hFFFF_F000, 5, 0, 0, 0, 0);
    // R4 absent entry with otherwise permitted rights
    doWalk(32'h0000_03FF, 2'd1, mkEntry(0, 2'd1, 22'h3F_FFFF), 32'hFFFF_F000, 4, 0, 0, 0, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule